// File: doc/BRIEF.md
# Low-Power Mode Controller with Wakeup Settling Timer

This block decides what happens when the processor issues a sleep request. It reads the current operating mode (high-speed, medium-speed or subactive) and the standby-select bit of an 8-bit control register. From these it picks one of four low-power states: sleep, subsleep, software standby or watch. A wake event from a sleep-type state returns the block to running at once. A wake event from a standby-type state first starts a settling timer. The clock-ready output stays low until the timer has counted the programmed number of states.

The control register also sets the settling-time code and the output-port enable. The output-port enable decides whether the address bus and bus control outputs float or keep driving during standby, during watch and during direct transfer. The register sits behind a single select line. A write of the reserved settling code is defined: it uses the longest hold time and raises an error flag. The settling counts scale from the parameter `BASE_LOG2`, whose default of 13 gives 8192 states for code 000.

Top module: `stby_ctrl`

## Requirements
- R1: The register reads as {standby-select at bit 7, settle code at bits 6:4, port-keep at bit 3, 3'b000 at bits 2:0} when `sel_i`=1 and `wr_i`=0, and reads 0 otherwise. Writes need `sel_i`=1 and `wr_i`=1. Bits 2:0 of a write are dropped, and a write with `sel_i`=0 changes nothing.
- R2: After reset the register reads 8'h08. `pstate_o` is 0 (run), `clk_ready_o`=1, `bus_oe_o`=1 and `rsv_err_o`=0.
- R3: With standby-select 0, a sleep request in run state moves `pstate_o` on the next clock. Current mode 0 (high) or 1 (medium) gives 1 (sleep), and current mode 2 (subactive) gives 2 (subsleep).
- R4: With standby-select 1, a sleep request in run state moves `pstate_o` on the next clock. Current mode 0 or 1 gives 3 (software standby), and current mode 2 gives 4 (watch).
- R5: The settling count for code k in 0..5 is 2^(BASE_LOG2+k) states. Code 3'b111 gives SHORT_STATES states (16 by default).
- R6: Writing code 3'b110 sets `rsv_err_o` from the next clock, reads back as 110, and gives a count of 2^(BASE_LOG2+5). A later write with any other code clears `rsv_err_o`.
- R7: A wake in software standby or watch moves `pstate_o` to 5 (settling) on the next clock. `clk_ready_o` is low in states 3, 4 and 5. It stays low for exactly the selected count of clocks after the wake edge, and then `pstate_o` returns to 0 with `clk_ready_o` high.
- R8: A wake during settling is ignored. A register write during settling does not change the count already running.
- R9: A wake in sleep or subsleep returns `pstate_o` to 0 on the next clock, and `clk_ready_o` stays high throughout.
- R10: With port-keep 0, `bus_oe_o` is low in states 3 and 4 and whenever `dxfer_i` is high. With port-keep 1, `bus_oe_o` is always high.
- R11: Outside run state, `act_mode_o` holds the mode latched at sleep entry. In run state it follows `cur_mode_i`.
- R12: A sleep request is ignored when `cur_mode_i` is 3 or when the block is not in run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Register address decode hit |
| wr_i | input | 1 | Write strobe (read when low) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| sleep_req_i | input | 1 | Sleep request pulse from the processor |
| wake_i | input | 1 | Wake event |
| cur_mode_i | input | 2 | Current active mode: 0 high, 1 medium, 2 subactive |
| dxfer_i | input | 1 | Direct transfer in progress |
| pstate_o | output | 3 | Power state: 0 run, 1 sleep, 2 subsleep, 3 standby, 4 watch, 5 settling |
| act_mode_o | output | 2 | Active mode to resume |
| clk_ready_o | output | 1 | Clock stable, normal operation allowed |
| bus_oe_o | output | 1 | Address bus and bus control output enable |
| rsv_err_o | output | 1 | Reserved settle code was written |

## Verification
If the settle counter is loaded with the wrong value or decrements wrongly, the length of the `clk_ready_o` low window changes. That shows up as a miscount by the time run state returns, at most one settle period after the wake. If the mode decode is wrong, `pstate_o` is wrong on the clock right after the sleep request. A latched resume mode that is corrupted shows on `act_mode_o` during the low-power state. If the reserved-code fallback is wrong, the 110 window is shorter than the expected longest count.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        ACT_HIGH = 2'd0,
        ACT_MED  = 2'd1,
        ACT_SUB  = 2'd2,
        ACT_BAD  = 2'd3
    } act_mode_e;

    typedef enum logic [2:0] {
        PS_RUN      = 3'd0,
        PS_SLEEP    = 3'd1,
        PS_SUBSLEEP = 3'd2,
        PS_SWSTBY   = 3'd3,
        PS_WATCH    = 3'd4,
        PS_SETTLE   = 3'd5
    } pstate_e;

    typedef struct packed {
        logic       stby_sel;
        logic [2:0] settle_code;
        logic       port_keep;
    } ctl_t;

    localparam logic [2:0] CODE_RSVD  = 3'b110;
    localparam logic [2:0] CODE_SHORT = 3'b111;
    localparam ctl_t CTL_RESET = '{stby_sel: 1'b0, settle_code: 3'b000, port_keep: 1'b1};

    function automatic logic [7:0] pack_ctl(input ctl_t c);
        return {c.stby_sel, c.settle_code, c.port_keep, 3'b000};
    endfunction

    function automatic ctl_t unpack_ctl(input logic [7:0] d);
        ctl_t c;
        c.stby_sel    = d[7];
        c.settle_code = d[6:4];
        c.port_keep   = d[3];
        return c;
    endfunction

    function automatic pstate_e sleep_target(input logic stby, input act_mode_e m);
        if (m == ACT_SUB) return stby ? PS_WATCH : PS_SUBSLEEP;
        return stby ? PS_SWSTBY : PS_SLEEP;
    endfunction

    function automatic logic is_standby(input pstate_e s);
        return (s == PS_SWSTBY) || (s == PS_WATCH);
    endfunction

endpackage

// File: rtl/stby_regfile.sv
module stby_regfile
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output ctl_t       ctl_o,
    output logic       rsv_err_o
);
    ctl_t ctl_q;
    logic err_q;
    logic wr_hit;

    assign wr_hit = sel_i && wr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
            err_q <= 1'b0;
        end else if (wr_hit) begin
            ctl_q <= unpack_ctl(wdata_i);
            err_q <= (wdata_i[6:4] == CODE_RSVD);
        end
    end

    assign rdata_o   = (sel_i && !wr_i) ? pack_ctl(ctl_q) : 8'h00;
    assign ctl_o     = ctl_q;
    assign rsv_err_o = err_q;

    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wdata_i[6:4] == CODE_RSVD) |=> rsv_err_o); // R6
    AST_HOLD_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        !sel_i |=> $stable(ctl_q)); // R1
endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer
    import stby_pkg::*;
#(
    parameter int BASE_LOG2    = 13,
    parameter int SHORT_STATES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [2:0] code_i,
    output logic       busy_o,
    output logic       done_o
);
    localparam int CNT_W = BASE_LOG2 + 6;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             busy_q;

    always_comb begin
        case (code_i)
            CODE_SHORT: load_val = CNT_W'(SHORT_STATES);
            CODE_RSVD:  load_val = CNT_W'(1) << (BASE_LOG2 + 5);
            default:    load_val = CNT_W'(1) << (BASE_LOG2 + int'(code_i));
        endcase
    end

    assign done_o = busy_q && (cnt_q == CNT_W'(1));
    assign busy_o = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start_i && !busy_q) begin
            cnt_q  <= load_val;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q > CNT_W'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1))); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (cnt_q == '0)); // R7
endmodule

// File: rtl/stby_mode_fsm.sv
module stby_mode_fsm
    import stby_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      stby_sel_i,
    input  logic      sleep_req_i,
    input  logic      wake_i,
    input  act_mode_e cur_mode_i,
    input  logic      settle_done_i,
    output pstate_e   state_o,
    output logic      start_settle_o,
    output act_mode_e saved_mode_o
);
    pstate_e   state_q;
    act_mode_e saved_q;

    assign start_settle_o = is_standby(state_q) && wake_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_RUN;
            saved_q <= ACT_HIGH;
        end else begin
            case (state_q)
                PS_RUN: begin
                    if (sleep_req_i && cur_mode_i != ACT_BAD) begin
                        state_q <= sleep_target(stby_sel_i, cur_mode_i);
                        saved_q <= cur_mode_i;
                    end
                end
                PS_SLEEP, PS_SUBSLEEP: begin
                    if (wake_i) state_q <= PS_RUN;
                end
                PS_SWSTBY, PS_WATCH: begin
                    if (wake_i) state_q <= PS_SETTLE;
                end
                PS_SETTLE: begin
                    if (settle_done_i) state_q <= PS_RUN;
                end
                default: state_q <= PS_RUN;
            endcase
        end
    end

    assign state_o      = state_q;
    assign saved_mode_o = saved_q;

    AST_SETTLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_SETTLE && $past(state_q) != PS_SETTLE) |->
        ($past(state_q) == PS_SWSTBY || $past(state_q) == PS_WATCH)); // R7
    AST_QUICK_WAKE: assert property (@(posedge clk) disable iff (rst)
        ((state_q == PS_SLEEP || state_q == PS_SUBSLEEP) && wake_i) |=> state_q == PS_RUN); // R9
    AST_SLEEP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_RUN && sleep_req_i && cur_mode_i != ACT_BAD) |=> state_q != PS_RUN); // R3
    AST_SAVED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_RUN) |=> $stable(saved_q)); // R11
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int BASE_LOG2    = 13,
    parameter int SHORT_STATES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic       sleep_req_i,
    input  logic       wake_i,
    input  logic [1:0] cur_mode_i,
    input  logic       dxfer_i,
    output logic [2:0] pstate_o,
    output logic [1:0] act_mode_o,
    output logic       clk_ready_o,
    output logic       bus_oe_o,
    output logic       rsv_err_o
);
    ctl_t      ctl;
    pstate_e   state;
    act_mode_e saved_mode;
    act_mode_e cur_mode;
    logic      start_settle;
    logic      settle_busy;
    logic      settle_done;

    assign cur_mode = act_mode_e'(cur_mode_i);

    stby_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (sel_i),
        .wr_i      (wr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .ctl_o     (ctl),
        .rsv_err_o (rsv_err_o)
    );

    stby_mode_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .stby_sel_i     (ctl.stby_sel),
        .sleep_req_i    (sleep_req_i),
        .wake_i         (wake_i),
        .cur_mode_i     (cur_mode),
        .settle_done_i  (settle_done),
        .state_o        (state),
        .start_settle_o (start_settle),
        .saved_mode_o   (saved_mode)
    );

    stby_settle_timer #(
        .BASE_LOG2    (BASE_LOG2),
        .SHORT_STATES (SHORT_STATES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_settle),
        .code_i  (ctl.settle_code),
        .busy_o  (settle_busy),
        .done_o  (settle_done)
    );

    assign pstate_o    = state;
    assign act_mode_o  = (state == PS_RUN) ? cur_mode_i : saved_mode;
    assign clk_ready_o = !(is_standby(state) || state == PS_SETTLE);
    assign bus_oe_o    = ctl.port_keep || !(is_standby(state) || dxfer_i);

    AST_SETTLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SETTLE) |-> settle_busy); // R7
    AST_KEEP_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SWSTBY && ctl.port_keep) |-> bus_oe_o); // R10
endmodule

// File: tb/stby_ctrl_tb.sv
module stby_ctrl_tb;
    localparam int BASE  = 6;
    localparam int SHORT = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       sel_i, wr_i, sleep_req_i, wake_i, dxfer_i;
    logic [7:0] wdata_i, rdata_o;
    logic [1:0] cur_mode_i, act_mode_o;
    logic [2:0] pstate_o;
    logic       clk_ready_o, bus_oe_o, rsv_err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    stby_ctrl #(.BASE_LOG2(BASE), .SHORT_STATES(SHORT)) u_dut (
        .clk(clk), .rst(rst), .sel_i(sel_i), .wr_i(wr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .sleep_req_i(sleep_req_i), .wake_i(wake_i),
        .cur_mode_i(cur_mode_i), .dxfer_i(dxfer_i), .pstate_o(pstate_o),
        .act_mode_o(act_mode_o), .clk_ready_o(clk_ready_o), .bus_oe_o(bus_oe_o),
        .rsv_err_o(rsv_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_states(input int code);
        if (code == 7) return SHORT;
        if (code == 6) return 1 << (BASE + 5);
        return 1 << (BASE + code);
    endfunction

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk);
        sel_i = 1; wr_i = 1; wdata_i = d;
        @(negedge clk);
        sel_i = 0; wr_i = 0; wdata_i = 0;
    endtask

    task automatic rd_reg(output logic [7:0] d);
        sel_i = 1; wr_i = 0;
        #1 d = rdata_o;
        sel_i = 0;
    endtask

    task automatic pulse_sleep(input logic [1:0] m);
        @(negedge clk);
        cur_mode_i = m; sleep_req_i = 1;
        @(negedge clk);
        sleep_req_i = 0;
    endtask

    task automatic pulse_wake();
        @(negedge clk);
        wake_i = 1;
        @(negedge clk);
        wake_i = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd_reg(d);
        chk("R2 reg", d, 8'h08);
        chk("R2 pstate", pstate_o, 0);
        chk("R2 ready", clk_ready_o, 1);
        chk("R2 oe", bus_oe_o, 1);
        chk("R2 err", rsv_err_o, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr_reg(8'hFF);
        rd_reg(d);
        chk("R1 low bits dropped", d, 8'hF8);
        @(negedge clk);
        sel_i = 0; wr_i = 1; wdata_i = 8'h00;
        @(negedge clk);
        wr_i = 0;
        rd_reg(d);
        chk("R1 no write without sel", d, 8'hF8);
        sel_i = 0; wr_i = 0; #1;
        chk("R1 read gated", rdata_o, 0);
        wr_reg(8'h08);
    endtask

    task automatic t_modes();
        int exp;
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 3; m++) begin
                wr_reg(s ? 8'hF8 : 8'h78);
                pulse_sleep(m[1:0]);
                if (m == 2) exp = s ? 4 : 2; else exp = s ? 3 : 1;
                chk(s ? "R4 target" : "R3 target", pstate_o, exp);
                cur_mode_i = 2'd0; #1;
                chk("R11 saved mode", act_mode_o, m);
                pulse_wake();
                if (s == 0) begin
                    chk("R9 quick wake", pstate_o, 0);
                    chk("R9 ready high", clk_ready_o, 1);
                end else begin
                    chk("R7 settle state", pstate_o, 5);
                    while (pstate_o != 0) @(negedge clk);
                end
            end
        end
    endtask

    task automatic t_settle(input int code, input bit extra_wake);
        int n = 0;
        wr_reg({1'b1, code[2:0], 4'b1000});
        pulse_sleep(2'd0);
        chk("R4 standby", pstate_o, 3);
        chk("R7 ready low in standby", clk_ready_o, 0);
        @(negedge clk);
        wake_i = 1;
        @(negedge clk);
        wake_i = 0;
        while (!clk_ready_o && n < 5000) begin
            n++;
            if (extra_wake && n == 3) begin
                wake_i = 1;
                sel_i = 1; wr_i = 1; wdata_i = 8'h08;
            end else begin
                wake_i = 0;
                sel_i = 0; wr_i = 0;
            end
            @(negedge clk);
        end
        wake_i = 0; sel_i = 0; wr_i = 0;
        chk(extra_wake ? "R8 count unchanged" : (code == 6 ? "R6 fallback count" : "R5 count"),
            n, exp_states(code));
        chk("R7 back to run", pstate_o, 0);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr_reg(8'hE8);
        chk("R6 err set", rsv_err_o, 1);
        rd_reg(d);
        chk("R6 readback", d[6:4], 6);
        t_settle(6, 0);
        wr_reg(8'h08);
        chk("R6 err cleared", rsv_err_o, 0);
    endtask

    task automatic t_bus();
        wr_reg(8'hF0);
        chk("R10 oe run", bus_oe_o, 1);
        @(negedge clk); dxfer_i = 1; #1;
        chk("R10 oe dxfer", bus_oe_o, 0);
        dxfer_i = 0;
        pulse_sleep(2'd2);
        chk("R10 watch state", pstate_o, 4);
        chk("R10 oe watch", bus_oe_o, 0);
        pulse_wake();
        while (pstate_o != 0) @(negedge clk);
        wr_reg(8'hF8);
        pulse_sleep(2'd1);
        chk("R10 oe keep", bus_oe_o, 1);
        pulse_wake();
        while (pstate_o != 0) @(negedge clk);
    endtask

    task automatic t_ignore();
        wr_reg(8'h08);
        pulse_sleep(2'd3);
        chk("R12 bad mode ignored", pstate_o, 0);
        pulse_sleep(2'd1);
        chk("R3 sleep", pstate_o, 1);
        pulse_sleep(2'd2);
        chk("R12 request in sleep ignored", pstate_o, 1);
        chk("R11 latched mode", act_mode_o, 1);
        pulse_wake();
        #1 chk("R11 follows in run", act_mode_o, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; sel_i = 0; wr_i = 0; wdata_i = 0; sleep_req_i = 0;
        wake_i = 0; cur_mode_i = 0; dxfer_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_regs();
        t_modes();
        for (int c = 0; c < 8; c++) if (c != 6) t_settle(c, 0);
        t_settle(7, 1);
        t_reserved();
        t_bus();
        t_ignore();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule